// File: doc/BRIEF.md
# Boot-Block Sector Map and Lock Guard

This block sits between the command front end of a 1 MiB byte-wide flash array and the engine that carries out erase and program work. It turns a 20-bit byte address into the index of the erase block that holds it. The map is non-uniform: large main blocks fill the low addresses, and small parameter and boot blocks fill the top. The block then decides whether a requested modify operation may go ahead. It reports a grant or a refusal cause, and it names the blocks the engine may alter.

The block holds the lock state itself. There is one lock bit per erase block. There is also a single permanent bit that, once set, freezes the block lock bits. A hardware protect pin and a programming-voltage-low flag also feed the decision. When a lock command is granted, the lock registers change on the same clock edge that registers the response.

Each request is a single cycle marked by `req_valid`. The response appears on the registered outputs one clock later.

Top module: `flg_lock_guard`

## Requirements
- R1: Addresses below 0xF0000 map to block index address>>16 (blocks 0 to 14, 64 KiB each). Addresses from 0xF0000 upward map to index 15 + ((address-0xF0000)>>13), which gives blocks 15 to 22 of 8 KiB each. Index 22 is the highest 8 KiB block at 0xFE000.
- R2: While `hw_prot_n` is 0, a byte write (op 0) or block erase (op 1) to a block whose lock bit is set is refused with code 2, and `rsp_mask` is zero. Otherwise it is granted, and `rsp_mask` is the one-hot of the addressed block.
- R3: While `hw_prot_n` is 1, block lock bits are ignored for byte write, block erase and full-chip erase. The permanent bit still refuses lock configuration.
- R4: Full-chip erase (op 2) is always granted with code 0. `rsp_mask` holds every block that is not effectively locked. `rsp_skip` is 1 when at least one block was left out, and 0 otherwise.
- R5: While `pgm_volt_low` is 1, every operation code from 0 to 5 is refused with code 1, and the lock state does not change.
- R6: While the permanent bit is set, set block lock (op 3) and clear block locks (op 5) are refused with code 3, and the lock bits stay unchanged.
- R7: Set permanent lock (op 4) is granted unless the voltage is low, and this includes when the bit is already set. Once set, `perm_lock` stays 1 until reset.
- R8: A granted set block lock sets only the bit of the addressed block. A granted clear block locks clears all 23 bits at once.
- R9: Response codes are 0 granted, 1 voltage low, 2 block locked and 3 permanent lock. `rsp_grant` is 1 exactly when the code is 0. Lock operations always give a zero `rsp_mask`.
- R10: A request at clock edge N is answered on the outputs after edge N, and lock changes are visible at that same time. An idle cycle, or op codes 6 and 7, gives `rsp_valid` 0 and leaves the lock state unchanged.
- R11: Reset clears `rsp_valid`, every lock bit and the permanent bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 3 | Operation: 0 write, 1 block erase, 2 chip erase, 3 set lock, 4 set permanent, 5 clear locks |
| req_addr | input | 20 | Byte address of the target |
| hw_prot_n | input | 1 | Protect pin; 0 enforces block lock bits |
| pgm_volt_low | input | 1 | Programming voltage below safe level |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Operation may proceed |
| rsp_code | output | 2 | Refusal cause |
| rsp_blk | output | 5 | Decoded block index of req_addr |
| rsp_mask | output | 23 | Blocks the engine may alter |
| rsp_skip | output | 1 | Chip erase left out at least one locked block |
| lock_bits | output | 23 | Current block lock bits |
| perm_lock | output | 1 | Current permanent lock bit |

## Verification
The bench builds the guard with its default geometry: fifteen 64 KiB blocks and eight 8 KiB blocks in a 20-bit space. With that geometry it can probe the seam between the two block sizes at 0xEFFFF and 0xF0000, and the boot block at the top of the space. The 23-bit masks are small enough to spell out by hand, so chip-erase masks with a mix of locked and unlocked blocks can be checked bit for bit. The stimulus steps through the lock tiers in order: block locks under both protect-pin levels, a voltage-low refusal that must leave no trace, a bulk clear, and then the permanent bit freezing all further lock changes.

// File: rtl/flg_pkg.sv
package flg_pkg;
  typedef enum logic [2:0] {
    OP_WRITE      = 3'd0,
    OP_BLK_ERASE  = 3'd1,
    OP_CHIP_ERASE = 3'd2,
    OP_SET_LOCK   = 3'd3,
    OP_SET_PERM   = 3'd4,
    OP_CLR_LOCKS  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    RC_OK     = 2'd0,
    RC_VOLT   = 2'd1,
    RC_LOCKED = 2'd2,
    RC_PERM   = 2'd3
  } rc_e;
endpackage

// File: rtl/flg_addr_map.sv
module flg_addr_map #(
  parameter int ADDR_W   = 20,
  parameter int MAIN_N   = 15,
  parameter int MAIN_SH  = 16,
  parameter int SMALL_SH = 13,
  parameter int IDX_W    = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] SMALL_BASE = ADDR_W'(MAIN_N) << MAIN_SH;

  logic [ADDR_W-1:0] small_off;
  assign small_off = addr - SMALL_BASE;

  always_comb begin
    if (addr < SMALL_BASE) idx = IDX_W'(addr >> MAIN_SH);
    else                   idx = IDX_W'(MAIN_N) + IDX_W'(small_off >> SMALL_SH);
  end
endmodule

// File: rtl/flg_policy.sv
module flg_policy
  import flg_pkg::*;
#(
  parameter int NBLK  = 23,
  parameter int IDX_W = 5
) (
  input  logic [2:0]       op,
  input  logic [IDX_W-1:0] idx,
  input  logic [NBLK-1:0]  locks,
  input  logic             perm,
  input  logic             prot_n,
  input  logic             volt_low,
  output logic             known,
  output rc_e              code,
  output logic [NBLK-1:0]  mask,
  output logic             skip,
  output logic             do_set,
  output logic             do_clr,
  output logic             do_perm
);
  logic [NBLK-1:0] eff_lock;
  logic [NBLK-1:0] onehot;

  assign eff_lock = locks & {NBLK{~prot_n}};
  assign onehot   = NBLK'(1) << idx;

  always_comb begin
    known   = 1'b1;
    code    = RC_OK;
    mask    = '0;
    skip    = 1'b0;
    do_set  = 1'b0;
    do_clr  = 1'b0;
    do_perm = 1'b0;
    case (op)
      OP_WRITE, OP_BLK_ERASE: begin
        if (volt_low)                code = RC_VOLT;
        else if (|(onehot & eff_lock)) code = RC_LOCKED;
        else                         mask = onehot;
      end
      OP_CHIP_ERASE: begin
        if (volt_low) code = RC_VOLT;
        else begin
          mask = ~eff_lock;
          skip = |eff_lock;
        end
      end
      OP_SET_LOCK: begin
        if (volt_low)  code = RC_VOLT;
        else if (perm) code = RC_PERM;
        else           do_set = 1'b1;
      end
      OP_CLR_LOCKS: begin
        if (volt_low)  code = RC_VOLT;
        else if (perm) code = RC_PERM;
        else           do_clr = 1'b1;
      end
      OP_SET_PERM: begin
        if (volt_low) code = RC_VOLT;
        else          do_perm = 1'b1;
      end
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/flg_lock_regs.sv
module flg_lock_regs #(
  parameter int NBLK  = 23,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_one,
  input  logic             clr_all,
  input  logic             set_perm,
  input  logic [IDX_W-1:0] idx,
  output logic [NBLK-1:0]  locks,
  output logic             perm
);
  for (genvar g = 0; g < NBLK; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                                 locks[g] <= 1'b0;
      else if (clr_all)                        locks[g] <= 1'b0;
      else if (set_one && (idx == IDX_W'(g)))  locks[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           perm <= 1'b0;
    else if (set_perm) perm <= 1'b1;
  end
endmodule

// File: rtl/flg_lock_guard.sv
module flg_lock_guard
  import flg_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int MAIN_N   = 15,
  parameter int SMALL_N  = 8,
  parameter int MAIN_SH  = 16,
  parameter int SMALL_SH = 13,
  parameter int NBLK     = MAIN_N + SMALL_N,
  parameter int IDX_W    = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              hw_prot_n,
  input  logic              pgm_volt_low,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic [1:0]        rsp_code,
  output logic [IDX_W-1:0]  rsp_blk,
  output logic [NBLK-1:0]   rsp_mask,
  output logic              rsp_skip,
  output logic [NBLK-1:0]   lock_bits,
  output logic              perm_lock
);
  logic [IDX_W-1:0] idx;
  logic             known, skip, do_set, do_clr, do_perm;
  rc_e              code;
  logic [NBLK-1:0]  mask;
  logic             take;

  flg_addr_map #(
    .ADDR_W(ADDR_W), .MAIN_N(MAIN_N), .MAIN_SH(MAIN_SH),
    .SMALL_SH(SMALL_SH), .IDX_W(IDX_W)
  ) u_map (.addr(req_addr), .idx(idx));

  flg_policy #(.NBLK(NBLK), .IDX_W(IDX_W)) u_pol (
    .op(req_op), .idx(idx), .locks(lock_bits), .perm(perm_lock),
    .prot_n(hw_prot_n), .volt_low(pgm_volt_low),
    .known(known), .code(code), .mask(mask), .skip(skip),
    .do_set(do_set), .do_clr(do_clr), .do_perm(do_perm)
  );

  assign take = req_valid && known;

  flg_lock_regs #(.NBLK(NBLK), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst),
    .set_one(take && do_set), .clr_all(take && do_clr),
    .set_perm(take && do_perm), .idx(idx),
    .locks(lock_bits), .perm(perm_lock)
  );

  always_ff @(posedge clk) begin
    if (rst || !take) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_code  <= 2'd0;
      rsp_blk   <= '0;
      rsp_mask  <= '0;
      rsp_skip  <= 1'b0;
    end else begin
      rsp_valid <= 1'b1;
      rsp_grant <= (code == RC_OK);
      rsp_code  <= code;
      rsp_blk   <= idx;
      rsp_mask  <= mask;
      rsp_skip  <= skip;
    end
  end
endmodule

// File: rtl/flg_checker.sv
module flg_checker #(
  parameter int ADDR_W = 20,
  parameter int NBLK   = 23,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              hw_prot_n,
  input logic              pgm_volt_low,
  input logic              rsp_valid,
  input logic              rsp_grant,
  input logic [1:0]        rsp_code,
  input logic [IDX_W-1:0]  rsp_blk,
  input logic [NBLK-1:0]   rsp_mask,
  input logic              rsp_skip,
  input logic [NBLK-1:0]   lock_bits,
  input logic              perm_lock
);
  AST_VOLT_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && pgm_volt_low && req_op <= 3'd5) |=> (rsp_valid && rsp_code == 2'd1 && !rsp_grant)); // R5
  AST_VOLT_NO_LOCK_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (pgm_volt_low) |=> ($stable(lock_bits) && (perm_lock == $past(perm_lock)))); // R5
  AST_PERM_FREEZE: assert property (@(posedge clk) disable iff (rst)
    perm_lock |=> $stable(lock_bits)); // R6
  AST_PERM_STICKY: assert property (@(posedge clk) disable iff (rst)
    perm_lock |=> perm_lock); // R7
  AST_MASK_RESPECTS_LOCK: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((rsp_mask & $past(lock_bits) & {NBLK{~$past(hw_prot_n)}}) == '0)); // R2
  AST_GRANT_CODE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_grant == (rsp_code == 2'd0))); // R9
  AST_REFUSED_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_grant) |-> (rsp_mask == '0)); // R9
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && $stable(lock_bits))); // R10
endmodule

bind flg_lock_guard flg_checker #(.ADDR_W(ADDR_W), .NBLK(NBLK), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_flg_lock_guard.sv
`timescale 1ns/100ps
module sim_flg_lock_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [19:0] req_addr = 20'd0;
  logic        hw_prot_n = 1'b0;
  logic        pgm_volt_low = 1'b0;
  logic        rsp_valid, rsp_grant, rsp_skip, perm_lock;
  logic [1:0]  rsp_code;
  logic [4:0]  rsp_blk;
  logic [22:0] rsp_mask, lock_bits;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flg_lock_guard u0 (.*);

  // op[55:53] addr[52:33] prot_n[32] vlow[31] code[30:29] blk[28:24] mask[23:1] skip[0]
  localparam int NV = 24;
  localparam logic [55:0] VEC [0:NV-1] = '{
    {3'd0, 20'h00000, 1'b0, 1'b0, 2'd0, 5'd0,  23'h000001, 1'b0}, // R1 R2 write blk0
    {3'd3, 20'h10000, 1'b0, 1'b0, 2'd0, 5'd1,  23'h000000, 1'b0}, // R8 lock blk1
    {3'd0, 20'h1FFFF, 1'b0, 1'b0, 2'd2, 5'd1,  23'h000000, 1'b0}, // R2 locked
    {3'd1, 20'h10000, 1'b1, 1'b0, 2'd0, 5'd1,  23'h000002, 1'b0}, // R3 pin high
    {3'd3, 20'hFE000, 1'b0, 1'b0, 2'd0, 5'd22, 23'h000000, 1'b0}, // R1 top boot
    {3'd1, 20'hEFFFF, 1'b0, 1'b0, 2'd0, 5'd14, 23'h004000, 1'b0}, // R1 seam low
    {3'd1, 20'hF0000, 1'b0, 1'b0, 2'd0, 5'd15, 23'h008000, 1'b0}, // R1 seam high
    {3'd0, 20'hFDFFF, 1'b0, 1'b0, 2'd0, 5'd21, 23'h200000, 1'b0}, // R1 blk21
    {3'd2, 20'h00000, 1'b0, 1'b0, 2'd0, 5'd0,  23'h3FFFFD, 1'b1}, // R4 skip
    {3'd2, 20'h00000, 1'b1, 1'b0, 2'd0, 5'd0,  23'h7FFFFF, 1'b0}, // R4 R3 full
    {3'd0, 20'h10000, 1'b0, 1'b1, 2'd1, 5'd1,  23'h000000, 1'b0}, // R5
    {3'd3, 20'h20000, 1'b0, 1'b1, 2'd1, 5'd2,  23'h000000, 1'b0}, // R5 lock refused
    {3'd0, 20'h20000, 1'b0, 1'b0, 2'd0, 5'd2,  23'h000004, 1'b0}, // R5 no effect
    {3'd5, 20'h00000, 1'b0, 1'b0, 2'd0, 5'd0,  23'h000000, 1'b0}, // R8 clear all
    {3'd0, 20'h10000, 1'b0, 1'b0, 2'd0, 5'd1,  23'h000002, 1'b0}, // R8 cleared
    {3'd3, 20'hF2000, 1'b0, 1'b0, 2'd0, 5'd16, 23'h000000, 1'b0}, // R8 lock blk16
    {3'd4, 20'h00000, 1'b0, 1'b0, 2'd0, 5'd0,  23'h000000, 1'b0}, // R7 set perm
    {3'd5, 20'h00000, 1'b1, 1'b0, 2'd3, 5'd0,  23'h000000, 1'b0}, // R6 R3 clear refused
    {3'd3, 20'h30000, 1'b0, 1'b0, 2'd3, 5'd3,  23'h000000, 1'b0}, // R6 set refused
    {3'd0, 20'h30000, 1'b0, 1'b0, 2'd0, 5'd3,  23'h000008, 1'b0}, // R6 blk3 free
    {3'd0, 20'hF2000, 1'b0, 1'b0, 2'd2, 5'd16, 23'h000000, 1'b0}, // R6 blk16 kept
    {3'd0, 20'hF2000, 1'b1, 1'b0, 2'd0, 5'd16, 23'h010000, 1'b0}, // R3
    {3'd4, 20'h00000, 1'b0, 1'b0, 2'd0, 5'd0,  23'h000000, 1'b0}, // R7 again
    {3'd4, 20'h00000, 1'b0, 1'b1, 2'd1, 5'd0,  23'h000000, 1'b0}  // R5 R7
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [2:0] op, input logic [19:0] a,
                       input logic pn, input logic vl);
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = a; hw_prot_n = pn; pgm_volt_low = vl;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R11 lock_bits", 64'(lock_bits), 64'd0);
    check("R11 perm_lock", 64'(perm_lock), 64'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      logic [1:0]  ec;
      v = VEC[i];
      issue(1'b1, v[55:53], v[52:33], v[32], v[31]);
      ec = v[30:29];
      check($sformatf("R10 valid v%0d", i), 64'(rsp_valid), 64'd1);
      check($sformatf("R9 code v%0d", i), 64'(rsp_code), 64'(ec));
      check($sformatf("R9 grant v%0d", i), 64'(rsp_grant), 64'(ec == 2'd0));
      check($sformatf("R1 blk v%0d", i), 64'(rsp_blk), 64'(v[28:24]));
      check($sformatf("R2 mask v%0d", i), 64'(rsp_mask), 64'(v[23:1]));
      check($sformatf("R4 skip v%0d", i), 64'(rsp_skip), 64'(v[0]));
    end

    check("R8 lock_bits final", 64'(lock_bits), 64'h010000);
    check("R7 perm held", 64'(perm_lock), 64'd1);

    issue(1'b1, 3'd6, 20'h00000, 1'b0, 1'b0);
    check("R10 op6 silent", 64'(rsp_valid), 64'd0);
    issue(1'b1, 3'd7, 20'hF2000, 1'b0, 1'b0);
    check("R10 op7 silent", 64'(rsp_valid), 64'd0);
    check("R10 op7 locks", 64'(lock_bits), 64'h010000);
    issue(1'b0, 3'd0, 20'h00000, 1'b0, 1'b0);
    check("R10 idle", 64'(rsp_valid), 64'd0);

    issue(1'b1, 3'd0, 20'h00000, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R11 reset valid", 64'(rsp_valid), 64'd0);
    check("R11 reset locks", 64'(lock_bits), 64'd0);
    check("R11 reset perm", 64'(perm_lock), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    issue(1'b1, 3'd3, 20'h40000, 1'b0, 1'b0);
    check("R7 R6 lock after reset", 64'(rsp_code), 64'd0);
    check("R8 blk4 only", 64'(lock_bits), 64'h000010);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule